// File: doc/BRIEF.md
# Halted-Core Coprocessor Access Arbiter

This block decides whether a move or block-transfer access to one of the two system coprocessors may go ahead or must be turned into an undefined-instruction response. One coprocessor holds the debug registers and the other holds system control. The decision follows special rules while the core is halted for debug. Outside the halted state it passes through the normal permission for the current mode. The register decoder upstream supplies two permission bits for the addressed register: one for user-level access and one for privileged-level access. The arbiter combines these bits with three things: the register group (taken from the coprocessor number and the opc1 field), the core's mode and security state, and the platform configuration.

The configuration covers three facts. It says whether the security extensions exist, whether halting debug of secure user code is supported, and whether the external debugger may rewrite the mode bits. A request strobe starts one decision. One cycle later the verdict is presented on a registered output, with a one-cycle valid pulse.

Top module: `cpacc_dbg_arbiter`

## Requirements
- R1: Coprocessor number `DBG_CP` (default 14) with opc1 equal to 0 selects the debug register group, and with any nonzero opc1 selects the non-debug group. `SYS_CP` (default 15) selects system control. Any other coprocessor number always gives undefined (verdict_ok = 0).
- R2: A block-transfer access (req_blk = 1) is refused unless it targets the debug register group.
- R3: With the core not halted, the verdict equals perm_user in user mode and perm_priv in any other mode.
- R4: While halted, an access whose user-level permission is set is permitted.
- R5: While halted, a debug-group access with privileged permission is permitted, whatever the mode and security state.
- R6: While halted, privileged permission applies when the core is in a privileged mode, or when the debugger may rewrite the mode bits (cfg_mode_wr = 1).
- R7: While halted, privileged permission also applies in three cases: the security extensions are absent, secure user halting debug is unsupported, or the core is non-secure.
- R8: While halted, in secure user mode with the mode bits locked, a non-debug-group or system-control access is refused unless perm_user is set or R9 applies.
- R9: While halted, with secure user halting debug supported, a system-control move flagged as cache maintenance is permitted whenever the privileged permission allows it.
- R10: While halted, no access is permitted when perm_priv is 0.
- R11: verdict_vld is 1 exactly in the cycle after a cycle with req_vld = 1. Reset clears verdict_vld and verdict_ok. verdict_ok keeps its value through cycles with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld | input | 1 | Access request strobe |
| req_cp | input | CP_W | Coprocessor number |
| req_opc1 | input | OPC1_W | opc1 field of the access |
| req_blk | input | 1 | 1 = block-transfer (load/store) form, 0 = move form |
| req_cache_op | input | 1 | Access is a cache-maintenance system-control operation |
| core_halted | input | 1 | Core is in the halted debug state |
| core_user | input | 1 | Core is in user mode |
| core_secure | input | 1 | Core is in the secure state |
| cfg_sec_ext | input | 1 | Security extensions present |
| cfg_su_halt | input | 1 | Secure user halting debug supported |
| cfg_mode_wr | input | 1 | Debugger may rewrite the mode bits |
| perm_user | input | 1 | Register permitted at user level outside debug |
| perm_priv | input | 1 | Register permitted at privileged level outside debug |
| verdict_vld | output | 1 | One-cycle pulse marking a new verdict |
| verdict_ok | output | 1 | 1 = permit, 0 = undefined |

## Verification
The assertions assume three things. Inputs are settled at each rising edge. req_vld is low throughout reset. The permission bits are sampled only in a cycle with req_vld high, so their values in idle cycles do not matter. The stimulus drives every input on the falling edge and holds req_vld low while rst_n is low. It then sweeps every combination of the control and configuration bits over a valid debug number, the system-control number and an out-of-range number, with opc1 both zero and nonzero. Idle gaps between request bursts exercise the valid pulse and the hold of the verdict.

// File: rtl/cpacc_pkg.sv
package cpacc_pkg;

   typedef enum logic [1:0] {
      GRP_DEBUG    = 2'd0,
      GRP_NONDEBUG = 2'd1,
      GRP_SYSCTL   = 2'd2,
      GRP_NONE     = 2'd3
   } cp_grp_e;

   typedef struct packed {
      logic halted;
      logic user;
      logic secure;
   } core_ctx_t;

   typedef struct packed {
      logic sec_ext;
      logic su_halt;
      logic mode_wr;
   } plat_cfg_t;

endpackage

// File: rtl/cpacc_decode.sv
module cpacc_decode
   import cpacc_pkg::*;
#(
   parameter int CP_W   = 4,
   parameter int OPC1_W = 3,
   parameter int DBG_CP = 14,
   parameter int SYS_CP = 15
) (
   input  logic [CP_W-1:0]   cp_num,
   input  logic [OPC1_W-1:0] opc1,
   input  logic              blk,
   output cp_grp_e           grp,
   output logic              shape_ok
);
   localparam logic [CP_W-1:0]   DBG_NUM  = CP_W'(DBG_CP);
   localparam logic [CP_W-1:0]   SYS_NUM  = CP_W'(SYS_CP);
   localparam logic [OPC1_W-1:0] OPC_ZERO = '0;

   always_comb begin
      if (cp_num == DBG_NUM)
         grp = (opc1 == OPC_ZERO) ? GRP_DEBUG : GRP_NONDEBUG;
      else if (cp_num == SYS_NUM)
         grp = GRP_SYSCTL;
      else
         grp = GRP_NONE;
   end

   // block transfers reach only the debug register group
   always_comb begin
      shape_ok = (grp != GRP_NONE) && (!blk || grp == GRP_DEBUG);
   end

endmodule

// File: rtl/cpacc_rules.sv
module cpacc_rules
   import cpacc_pkg::*;
#(
   parameter bit CACHE_BYPASS = 1'b1
) (
   input  cp_grp_e   grp,
   input  logic      shape_ok,
   input  core_ctx_t ctx,
   input  plat_cfg_t cfg,
   input  logic      perm_user,
   input  logic      perm_priv,
   input  logic      cache_op,
   output logic      permit
);
   logic normal_ok;
   logic mode_free;
   logic cache_term;
   logic halted_ok;

   always_comb begin
      normal_ok = ctx.user ? perm_user : perm_priv;
      mode_free = !ctx.user || cfg.mode_wr || !cfg.sec_ext
                  || !cfg.su_halt || !ctx.secure;
   end

   generate
      if (CACHE_BYPASS) begin : g_cache_on
         always_comb cache_term = cfg.su_halt && cache_op && (grp == GRP_SYSCTL);
      end else begin : g_cache_off
         logic unused_cache;
         always_comb unused_cache = cache_op;
         always_comb cache_term = 1'b0;
      end
   endgenerate

   always_comb begin
      halted_ok = perm_priv &&
                  (perm_user || grp == GRP_DEBUG || mode_free || cache_term);
      permit    = shape_ok && (ctx.halted ? halted_ok : normal_ok);
   end

endmodule

// File: rtl/cpacc_verdict_reg.sv
module cpacc_verdict_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic permit_d,
   output logic vld_q,
   output logic ok_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         ok_q  <= 1'b0;
      end else begin
         vld_q <= take;
         if (take)
            ok_q <= permit_d;
      end
   end
endmodule

// File: rtl/cpacc_dbg_arbiter.sv
module cpacc_dbg_arbiter
   import cpacc_pkg::*;
#(
   parameter int CP_W         = 4,
   parameter int OPC1_W       = 3,
   parameter int DBG_CP       = 14,
   parameter int SYS_CP       = 15,
   parameter bit CACHE_BYPASS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_vld,
   input  logic [CP_W-1:0]   req_cp,
   input  logic [OPC1_W-1:0] req_opc1,
   input  logic              req_blk,
   input  logic              req_cache_op,
   input  logic              core_halted,
   input  logic              core_user,
   input  logic              core_secure,
   input  logic              cfg_sec_ext,
   input  logic              cfg_su_halt,
   input  logic              cfg_mode_wr,
   input  logic              perm_user,
   input  logic              perm_priv,
   output logic              verdict_vld,
   output logic              verdict_ok
);
   localparam int CP_SPAN = 1 << CP_W;

   generate
      if (CP_W < 1 || CP_W > 8) begin : g_bad_cpw
         $error("cpacc_dbg_arbiter: CP_W out of range");
      end
      if (OPC1_W < 1) begin : g_bad_opc
         $error("cpacc_dbg_arbiter: OPC1_W must be positive");
      end
      if (DBG_CP < 0 || DBG_CP >= CP_SPAN || SYS_CP < 0 || SYS_CP >= CP_SPAN) begin : g_bad_num
         $error("cpacc_dbg_arbiter: coprocessor number does not fit CP_W");
      end
      if (DBG_CP == SYS_CP) begin : g_same_num
         $error("cpacc_dbg_arbiter: debug and system numbers must differ");
      end
   endgenerate

   cp_grp_e   grp;
   logic      shape_ok;
   logic      permit_d;
   core_ctx_t ctx;
   plat_cfg_t cfg;

   always_comb begin
      ctx = '{halted: core_halted, user: core_user, secure: core_secure};
      cfg = '{sec_ext: cfg_sec_ext, su_halt: cfg_su_halt, mode_wr: cfg_mode_wr};
   end

   cpacc_decode #(
      .CP_W(CP_W), .OPC1_W(OPC1_W), .DBG_CP(DBG_CP), .SYS_CP(SYS_CP)
   ) u_decode (
      .cp_num(req_cp), .opc1(req_opc1), .blk(req_blk),
      .grp(grp), .shape_ok(shape_ok)
   );

   cpacc_rules #(.CACHE_BYPASS(CACHE_BYPASS)) u_rules (
      .grp(grp), .shape_ok(shape_ok), .ctx(ctx), .cfg(cfg),
      .perm_user(perm_user), .perm_priv(perm_priv),
      .cache_op(req_cache_op), .permit(permit_d)
   );

   cpacc_verdict_reg u_out (
      .clk(clk), .rst_n(rst_n), .take(req_vld), .permit_d(permit_d),
      .vld_q(verdict_vld), .ok_q(verdict_ok)
   );

endmodule

// File: rtl/cpacc_dbg_arbiter_chk.sv
module cpacc_dbg_arbiter_chk #(
   parameter int CP_W         = 4,
   parameter int OPC1_W       = 3,
   parameter int DBG_CP       = 14,
   parameter int SYS_CP       = 15,
   parameter bit CACHE_BYPASS = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_vld,
   input logic [CP_W-1:0]   req_cp,
   input logic [OPC1_W-1:0] req_opc1,
   input logic              req_blk,
   input logic              req_cache_op,
   input logic              core_halted,
   input logic              core_user,
   input logic              core_secure,
   input logic              cfg_sec_ext,
   input logic              cfg_su_halt,
   input logic              cfg_mode_wr,
   input logic              perm_user,
   input logic              perm_priv,
   input logic              verdict_vld,
   input logic              verdict_ok
);
   logic is_dbg, is_sys, dbg_grp, known;
   always_comb begin
      is_dbg  = (req_cp == CP_W'(DBG_CP));
      is_sys  = (req_cp == CP_W'(SYS_CP));
      dbg_grp = is_dbg && (req_opc1 == '0);
      known   = is_dbg || is_sys;
   end

   p_unknown_cp_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && !known) |=> !verdict_ok);

   p_blk_only_debug_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && req_blk && !dbg_grp) |=> !verdict_ok);

   p_normal_user_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && !core_halted && core_user && !perm_user) |=> !verdict_ok);

   p_user_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && known && !req_blk && perm_user && perm_priv) |=> verdict_ok);

   p_debug_group_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && core_halted && dbg_grp && perm_priv) |=> verdict_ok);

   p_mode_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && core_halted && known && !req_blk && cfg_mode_wr && perm_priv) |=> verdict_ok);

   p_no_secext_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && core_halted && known && !req_blk && !cfg_sec_ext && perm_priv) |=> verdict_ok);

   p_locked_su_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && core_halted && core_user && core_secure && cfg_sec_ext && cfg_su_halt
       && !cfg_mode_wr && !dbg_grp && !perm_user && !req_cache_op) |=> !verdict_ok);

   generate
      if (CACHE_BYPASS) begin : g_cache_chk
         p_cache_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (req_vld && core_halted && is_sys && !req_blk && req_cache_op
             && cfg_su_halt && perm_priv) |=> verdict_ok);
      end
   endgenerate

   p_priv_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && core_halted && !perm_priv) |=> !verdict_ok);

   p_vld_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |=> verdict_vld);

   p_vld_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld |=> !verdict_vld);

   p_ok_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld |=> $stable(verdict_ok));

endmodule

bind cpacc_dbg_arbiter cpacc_dbg_arbiter_chk #(
   .CP_W(CP_W), .OPC1_W(OPC1_W), .DBG_CP(DBG_CP), .SYS_CP(SYS_CP),
   .CACHE_BYPASS(CACHE_BYPASS)
) u_chk (.*);

// File: tb/cpacc_dbg_arbiter_tb_top.sv
module cpacc_dbg_arbiter_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int CP_W   = 4;
   localparam int OPC1_W = 3;
   localparam int WATCHDOG_CYCLES = 60000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_vld = 1'b0;
   logic [CP_W-1:0] req_cp = '0;
   logic [OPC1_W-1:0] req_opc1 = '0;
   logic req_blk = 1'b0, req_cache_op = 1'b0;
   logic core_halted = 1'b0, core_user = 1'b0, core_secure = 1'b0;
   logic cfg_sec_ext = 1'b0, cfg_su_halt = 1'b0, cfg_mode_wr = 1'b0;
   logic perm_user = 1'b0, perm_priv = 1'b0;
   logic verdict_vld, verdict_ok;

   always #(CLK_PERIOD/2) clk = ~clk;

   cpacc_dbg_arbiter dut_i (.*);

   typedef struct { bit ok; int tag; } exp_t;
   exp_t exp_q[$];

   int checks = 0;
   int failures = 0;
   int sent = 0;
   int seen = 0;
   bit done = 1'b0;

   function automatic string tag_name(input int t);
      case (t)
         1: return "R1";   2: return "R2";   3: return "R3";
         4: return "R4";   5: return "R5";   6: return "R6";
         7: return "R7";   8: return "R8";   9: return "R9";
         10: return "R10"; default: return "R11";
      endcase
   endfunction

   task automatic check(input bit cond, input string req, input int act, input int exp);
      checks++;
      if (!cond) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // behavioural model of the requirements
   function automatic exp_t model(input int cp, input int opc, input bit blk, input bit halt,
                                  input bit usr, input bit sec, input bit sx, input bit su,
                                  input bit mw, input bit pu, input bit pp, input bit co);
      exp_t e;
      bit dbg;
      dbg = (cp == 14) && (opc == 0);
      if (cp != 14 && cp != 15)      e = '{0, 1};   // R1
      else if (blk && !dbg)          e = '{0, 2};   // R2
      else if (!halt)                e = '{usr ? pu : pp, 3}; // R3
      else if (!pp)                  e = '{0, 10};  // R10
      else if (pu)                   e = '{1, 4};   // R4
      else if (dbg)                  e = '{1, 5};   // R5
      else if (!usr || mw)           e = '{1, 6};   // R6
      else if (!sx || !su || !sec)   e = '{1, 7};   // R7
      else if (cp == 15 && co)       e = '{1, 9};   // R9
      else                           e = '{0, 8};   // R8
      return e;
   endfunction

   task automatic send(input int cp, input int opc, input bit blk, input bit halt, input bit usr,
                       input bit sec, input bit sx, input bit su, input bit mw, input bit pu,
                       input bit pp, input bit co);
      req_vld = 1'b1; req_cp = CP_W'(cp); req_opc1 = OPC1_W'(opc); req_blk = blk;
      core_halted = halt; core_user = usr; core_secure = sec;
      cfg_sec_ext = sx; cfg_su_halt = su; cfg_mode_wr = mw;
      perm_user = pu; perm_priv = pp; req_cache_op = co;
      exp_q.push_back(model(cp, opc, blk, halt, usr, sec, sx, su, mw, pu, pp, co));
      sent++;
      @(negedge clk);
      req_vld = 1'b0;
   endtask

   // monitor: compare each verdict with the queued expectation
   always @(negedge clk) begin
      if (rst_n && verdict_vld) begin
         seen++;
         if (exp_q.size() == 0) begin
            check(1'b0, "R11", 1, 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(verdict_ok == e.ok, tag_name(e.tag), int'(verdict_ok), int'(e.ok));
         end
      end
   end

   initial begin
      int cps[3];
      int opcs[3];
      logic held;
      cps = '{14, 15, 3};
      opcs = '{0, 1, 5};
      repeat (3) @(negedge clk);
      check(verdict_vld == 1'b0 && verdict_ok == 1'b0, "R11", int'(verdict_vld), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(verdict_vld == 1'b0, "R11", int'(verdict_vld), 0);

      // directed: cache-op bypass in locked secure user, then idle hold
      send(15, 2, 0, 1, 1, 1, 1, 1, 0, 0, 1, 1);   // R9 permit
      @(negedge clk);
      check(verdict_vld == 1'b0, "R11", int'(verdict_vld), 0);
      check(verdict_ok == 1'b1, "R11", int'(verdict_ok), 1);
      perm_priv = 1'b0; req_cp = 4'd3;               // ignored without a request
      @(negedge clk);
      check(verdict_ok == 1'b1, "R11", int'(verdict_ok), 1);
      send(14, 3, 0, 1, 1, 1, 1, 1, 0, 0, 1, 0);   // R8 refuse
      send(14, 0, 1, 1, 1, 1, 1, 1, 0, 0, 1, 0);   // R5 block transfer to debug group
      send(15, 0, 1, 0, 0, 0, 0, 0, 0, 1, 1, 0);   // R2 refuse
      @(negedge clk);

      // exhaustive sweep, back-to-back, with gaps between coprocessor blocks
      foreach (cps[i]) begin
         foreach (opcs[j]) begin
            for (int v = 0; v < 1024; v++) begin
               send(cps[i], opcs[j], v[0], v[1], v[2], v[3], v[4], v[5], v[6],
                    v[7], v[8], v[9]);
            end
            @(negedge clk);
            held = verdict_ok;
            @(negedge clk);
            check(verdict_vld == 1'b0, "R11", int'(verdict_vld), 0);
            check(verdict_ok == held, "R11", int'(verdict_ok), int'(held));
         end
      end
      repeat (2) @(negedge clk);
      check(exp_q.size() == 0 && seen == sent, "R11", seen, sent);
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < WATCHDOG_CYCLES && !done; c++) @(posedge clk);
      if (!done) check(1'b0, "R11 watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule